// File: doc/BRIEF.md
# Local TDM Serial Stream Multiplexer

The block carries four logical serial streams, framed in 2048-cycle frames of a 16.384 MHz master clock, between four serial output pins, four serial input pins and a parallel byte store. A host fills the transmit side and collects received bytes one channel byte at a time. Each byte is addressed by stream number and channel number (32 channels per stream).

A two-bit arrangement field picks how the four streams land on the pins. At 2 Mb/s each pin carries one stream. When two or four streams share one pin, that pin runs at 4 or 8 Mb/s and the streams' channels are interleaved byte by byte. A mixed arrangement keeps two pins at 2 Mb/s and runs a third at 4 Mb/s. The arrangement is sampled only at a frame boundary, so a change never tears a frame.

Both host ports are valid/ready. Ready stays low while reset is asserted and high at all other times, so after reset neither port ever stalls. A transfer happens on a clock edge where valid and ready are both high. The requester must hold the address and data stable until that edge. The read response has no back-pressure: it is presented for exactly one cycle, one cycle after the request is accepted.

Top module: `tdm_stream_mux`

## Requirements
- R1: With `arr_sel`=0, every pin p carries stream p. There are 32 channels per frame and each bit cell lasts 8 master cycles.
- R2: With `arr_sel`=1, pin 0 carries streams 0 and 1 and pin 2 carries streams 2 and 3. Each has 64 channels per frame and 4-cycle bit cells.
- R3: With `arr_sel`=2, pin 0 carries all four streams in 128 channels per frame with 2-cycle bit cells. Only pin 0 is enabled.
- R4: With `arr_sel`=3, pins 0 and 1 carry streams 0 and 1 with 8-cycle cells. Pin 2 carries streams 2 and 3 with 4-cycle cells.
- R5: On a pin shared by N streams whose lowest stream is b, pin channel k carries channel k/N (integer division) of stream b + (k mod N).
- R6: Bytes go out MSB first. Bit i (0 = MSB) of pin channel k occupies frame positions k·8D + i·D through k·8D + i·D + D − 1, where D is the cell length in cycles.
- R7: A pin that the active arrangement does not use drives `ser_out` high and `ser_oe` low. A used pin has `ser_oe` high.
- R8: The frame position counts 0 to 2047 from the first edge after reset. Reset selects arrangement 0. A new `arr_sel` value takes effect only at the first frame position 0 after it is applied.
- R9: Each input bit is sampled in the last cycle of its cell. The assembled byte is stored for its stream and channel at the end of the slot, and a host read returns the most recent stored byte.
- R10: The byte sent in a slot is the stored transmit byte as it stood in the last cycle of the preceding slot. A write that lands later affects only the next frame.
- R11: A host read accepted on an edge makes `rsp_valid` high with the addressed byte in the following cycle only. A host write accepted on an edge updates the addressed transmit byte.
- R12: While `rst` is high, `wr_ready` and `rd_ready` are low. After reset they are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz master clock |
| rst | input | 1 | Synchronous reset, active high |
| arr_sel | input | 2 | Pin and rate arrangement (0..3) |
| wr_valid | input | 1 | Transmit byte write request |
| wr_ready | output | 1 | Write request can be accepted |
| wr_stream | input | 2 | Stream of the byte written |
| wr_chan | input | 5 | Channel of the byte written |
| wr_data | input | 8 | Transmit byte |
| rd_valid | input | 1 | Receive byte read request |
| rd_ready | output | 1 | Read request can be accepted |
| rd_stream | input | 2 | Stream of the byte read |
| rd_chan | input | 5 | Channel of the byte read |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_data | output | 8 | Read data |
| ser_in | input | 4 | Serial input pins |
| ser_out | output | 4 | Serial output pins |
| ser_oe | output | 4 | Output enable per serial pin |

## Verification
Assertions check on every cycle that the frame position wraps from 2047 to 0, that the active arrangement only moves at position 0, that the pin enables agree with the active arrangement, that at most one receive store occurs per cycle when all streams share one pin, and that read responses follow accepted requests. The bench scenarios alone can show the channel-to-stream interleave on each pin, the bit order and cell timing, and the value of the idle pins. They also show the slot-ahead fetch of transmit bytes and the round trip through the receive store, with the outputs looped back to the inputs.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int NLANE = 4;

  typedef enum logic [1:0] {
    ARR_X2  = 2'd0,
    ARR_X4  = 2'd1,
    ARR_X8  = 2'd2,
    ARR_MIX = 2'd3
  } arr_e;

  // act: pin in use; base: lowest stream; nlog: log2(streams on pin);
  // dlog: log2(cycles per bit cell)
  typedef struct packed {
    logic       act;
    logic [1:0] base;
    logic [1:0] nlog;
    logic [1:0] dlog;
  } lane_map_t;

  function automatic lane_map_t map_lane(logic [1:0] arr, logic [1:0] pin);
    lane_map_t r;
    r.act  = 1'b0;
    r.base = pin;
    r.nlog = 2'd0;
    r.dlog = 2'd3;
    case (arr_e'(arr))
      ARR_X2: r.act = 1'b1;
      ARR_X4: if (!pin[0]) begin
        r.act = 1'b1; r.nlog = 2'd1; r.dlog = 2'd2;
      end
      ARR_X8: if (pin == 2'd0) begin
        r.act = 1'b1; r.nlog = 2'd2; r.dlog = 2'd1;
      end
      default: if (pin != 2'd3) begin
        r.act = 1'b1;
        if (pin == 2'd2) begin r.nlog = 2'd1; r.dlog = 2'd2; end
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
  parameter int FRAME = 2048,
  parameter int CNT_W = $clog2(FRAME)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       arr_sel,
  output logic [CNT_W-1:0] cnt,
  output logic             frame_end,
  output logic [1:0]       arr_act
);
  assign frame_end = (cnt == CNT_W'(FRAME - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      arr_act <= 2'd0;
    end else begin
      cnt <= frame_end ? '0 : cnt + 1'b1;
      if (frame_end) arr_act <= arr_sel;
    end
  end

  // R8: frame position wraps to zero after its last cycle
  p_frame_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (cnt == '0));

  // R8: arrangement only moves when a frame begins
  p_arr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> $stable(arr_act));
endmodule

// File: rtl/tdm_pin_lane.sv
module tdm_pin_lane import tdm_pkg::*; #(
  parameter int PIN   = 0,
  parameter int CNT_W = 11,
  parameter int CH_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic             frame_end,
  input  logic [1:0]       arr_act,
  input  logic [1:0]       arr_next,
  input  logic             ser_in,
  output logic             ser_out,
  output logic             ser_oe,
  output logic [1:0]       fetch_stream,
  output logic [CH_W-1:0]  fetch_chan,
  input  logic [7:0]       tx_byte,
  output logic             rx_we,
  output logic [1:0]       rx_stream,
  output logic [CH_W-1:0]  rx_chan,
  output logic [7:0]       rx_byte
);
  lane_map_t        m, mn;
  logic [CNT_W-1:0] cell_mask, slot_mask, k, ncnt, nk;
  logic [2:0]       bit_idx;
  logic             cell_end, slot_end;
  logic [7:0]       tx_sh, rx_sh;

  always_comb begin
    m         = map_lane(arr_act, 2'(PIN));
    mn        = map_lane(frame_end ? arr_next : arr_act, 2'(PIN));
    cell_mask = CNT_W'((1 << m.dlog) - 1);
    slot_mask = CNT_W'((8 << m.dlog) - 1);
    cell_end  = ((cnt & cell_mask) == cell_mask);
    slot_end  = ((cnt & slot_mask) == slot_mask);
    bit_idx   = 3'(cnt >> m.dlog);
    k         = cnt >> (int'(m.dlog) + 3);
    rx_stream = m.base + 2'(k & CNT_W'((1 << m.nlog) - 1));
    rx_chan   = CH_W'(k >> m.nlog);
    // next slot, seen through the arrangement valid in the next cycle
    ncnt         = frame_end ? '0 : cnt + 1'b1;
    nk           = ncnt >> (int'(mn.dlog) + 3);
    fetch_stream = mn.base + 2'(nk & CNT_W'((1 << mn.nlog) - 1));
    fetch_chan   = CH_W'(nk >> mn.nlog);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh <= '0;
      rx_sh <= '0;
    end else begin
      if (frame_end || (m.act && slot_end))
        tx_sh <= mn.act ? tx_byte : 8'hFF;
      if (m.act && cell_end)
        rx_sh <= {rx_sh[6:0], ser_in};
    end
  end

  assign ser_out = m.act ? tx_sh[3'd7 - bit_idx] : 1'b1;
  assign ser_oe  = m.act;
  assign rx_we   = m.act && slot_end;
  assign rx_byte = {rx_sh[6:0], ser_in};
endmodule

// File: rtl/tdm_byte_store.sv
module tdm_byte_store import tdm_pkg::*; #(
  parameter int CH   = 32,
  parameter int CH_W = $clog2(CH)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_valid,
  output logic                        wr_ready,
  input  logic [1:0]                  wr_stream,
  input  logic [CH_W-1:0]             wr_chan,
  input  logic [7:0]                  wr_data,
  input  logic                        rd_valid,
  output logic                        rd_ready,
  input  logic [1:0]                  rd_stream,
  input  logic [CH_W-1:0]             rd_chan,
  output logic                        rsp_valid,
  output logic [7:0]                  rsp_data,
  input  logic [NLANE-1:0][1:0]       fetch_stream,
  input  logic [NLANE-1:0][CH_W-1:0]  fetch_chan,
  output logic [NLANE-1:0][7:0]       tx_byte,
  input  logic [NLANE-1:0]            rx_we,
  input  logic [NLANE-1:0][1:0]       rx_stream,
  input  logic [NLANE-1:0][CH_W-1:0]  rx_chan,
  input  logic [NLANE-1:0][7:0]       rx_byte
);
  logic [7:0] tx_mem [NLANE][CH];
  logic [7:0] rx_mem [NLANE][CH];

  assign wr_ready = !rst;
  assign rd_ready = !rst;

  for (genvar p = 0; p < NLANE; p++) begin : g_fetch
    assign tx_byte[p] = tx_mem[fetch_stream[p]][fetch_chan[p]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NLANE; s++)
        for (int c = 0; c < CH; c++) begin
          tx_mem[s][c] <= '0;
          rx_mem[s][c] <= '0;
        end
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (wr_valid && wr_ready) tx_mem[wr_stream][wr_chan] <= wr_data;
      for (int p = 0; p < NLANE; p++)
        if (rx_we[p]) rx_mem[rx_stream[p]][rx_chan[p]] <= rx_byte[p];
      rsp_valid <= rd_valid && rd_ready;
      if (rd_valid && rd_ready) rsp_data <= rx_mem[rd_stream][rd_chan];
    end
  end

  // R11: a response appears only after an accepted read
  p_rsp_after_req_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(rd_valid && rd_ready));
endmodule

// File: rtl/tdm_stream_mux.sv
module tdm_stream_mux import tdm_pkg::*; #(
  parameter int CH = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            arr_sel,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [1:0]            wr_stream,
  input  logic [$clog2(CH)-1:0] wr_chan,
  input  logic [7:0]            wr_data,
  input  logic                  rd_valid,
  output logic                  rd_ready,
  input  logic [1:0]            rd_stream,
  input  logic [$clog2(CH)-1:0] rd_chan,
  output logic                  rsp_valid,
  output logic [7:0]            rsp_data,
  input  logic [3:0]            ser_in,
  output logic [3:0]            ser_out,
  output logic [3:0]            ser_oe
);
  localparam int CH_W  = $clog2(CH);
  localparam int FRAME = 64 * CH;
  localparam int CNT_W = $clog2(FRAME);

  logic [CNT_W-1:0]            cnt;
  logic                        frame_end;
  logic [1:0]                  arr_act;
  logic [NLANE-1:0][1:0]       fetch_stream, rx_stream;
  logic [NLANE-1:0][CH_W-1:0]  fetch_chan, rx_chan;
  logic [NLANE-1:0][7:0]       tx_byte, rx_byte;
  logic [NLANE-1:0]            rx_we;

  tdm_frame_timer #(.FRAME(FRAME), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .arr_sel(arr_sel),
    .cnt(cnt), .frame_end(frame_end), .arr_act(arr_act)
  );

  for (genvar p = 0; p < NLANE; p++) begin : g_lane
    tdm_pin_lane #(.PIN(p), .CNT_W(CNT_W), .CH_W(CH_W)) u_lane (
      .clk(clk), .rst(rst), .cnt(cnt), .frame_end(frame_end),
      .arr_act(arr_act), .arr_next(arr_sel),
      .ser_in(ser_in[p]), .ser_out(ser_out[p]), .ser_oe(ser_oe[p]),
      .fetch_stream(fetch_stream[p]), .fetch_chan(fetch_chan[p]),
      .tx_byte(tx_byte[p]),
      .rx_we(rx_we[p]), .rx_stream(rx_stream[p]), .rx_chan(rx_chan[p]),
      .rx_byte(rx_byte[p])
    );
  end

  tdm_byte_store #(.CH(CH), .CH_W(CH_W)) u_store (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_stream(wr_stream),
    .wr_chan(wr_chan), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_stream(rd_stream),
    .rd_chan(rd_chan), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .fetch_stream(fetch_stream), .fetch_chan(fetch_chan), .tx_byte(tx_byte),
    .rx_we(rx_we), .rx_stream(rx_stream), .rx_chan(rx_chan), .rx_byte(rx_byte)
  );

  // R1: every pin enabled in the one-stream-per-pin arrangement
  p_oe_all_r1: assert property (@(posedge clk) disable iff (rst)
    (arr_act == ARR_X2) |-> (ser_oe == 4'hF));

  // R3: only pin 0 enabled when all streams share it
  p_oe_single_r3: assert property (@(posedge clk) disable iff (rst)
    (arr_act == ARR_X8) |-> (ser_oe == 4'b0001));

  // R5: one shared pin can store at most one byte per cycle
  p_one_store_r5: assert property (@(posedge clk) disable iff (rst)
    (arr_act == ARR_X8) |-> ($countones(rx_we) <= 1));
endmodule

// File: tb/test_tdm_stream_mux.sv
module test_tdm_stream_mux;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] arr_sel = 2'd0;
  logic       wr_valid = 1'b0, rd_valid = 1'b0;
  logic       wr_ready, rd_ready, rsp_valid;
  logic [1:0] wr_stream = '0, rd_stream = '0;
  logic [4:0] wr_chan = '0, rd_chan = '0;
  logic [7:0] wr_data = '0, rsp_data;
  logic [3:0] ser_out, ser_oe, ser_in;
  int         n_chk = 0, n_fail = 0;
  int         tcnt = 0;
  int         cycles = 0;

  assign ser_in = ser_out;  // loopback

  always #2 clk = ~clk;

  tdm_stream_mux i_tdm_stream_mux (
    .clk(clk), .rst(rst), .arr_sel(arr_sel),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_stream(wr_stream),
    .wr_chan(wr_chan), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_stream(rd_stream),
    .rd_chan(rd_chan), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ser_in(ser_in), .ser_out(ser_out), .ser_oe(ser_oe)
  );

  // frame position from the requirement: 0..2047 from the first edge after reset
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) tcnt <= 0;
    else     tcnt <= (tcnt == 2047) ? 0 : tcnt + 1;
  end

  always @(posedge clk) if (cycles > 190000) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=<190000 cycles", cycles);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  typedef struct packed {
    logic [1:0] arr;
    logic [1:0] pin;
    logic [7:0] k;
    logic [2:0] s;   // 7 = pin unused
    logic [4:0] c;
    logic [3:0] d;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{2'd0, 2'd0, 8'd5,   3'd0, 5'd5,  4'd8},  // R1
    '{2'd0, 2'd3, 8'd31,  3'd3, 5'd31, 4'd8},  // R1
    '{2'd1, 2'd0, 8'd0,   3'd0, 5'd0,  4'd4},  // R2
    '{2'd1, 2'd0, 8'd7,   3'd1, 5'd3,  4'd4},  // R2 R5
    '{2'd1, 2'd2, 8'd63,  3'd3, 5'd31, 4'd4},  // R2 R5
    '{2'd1, 2'd1, 8'd0,   3'd7, 5'd0,  4'd4},  // R7
    '{2'd2, 2'd0, 8'd6,   3'd2, 5'd1,  4'd2},  // R3 R5
    '{2'd2, 2'd0, 8'd127, 3'd3, 5'd31, 4'd2},  // R3 R5
    '{2'd2, 2'd3, 8'd0,   3'd7, 5'd0,  4'd2},  // R7
    '{2'd3, 2'd1, 8'd10,  3'd1, 5'd10, 4'd8},  // R4
    '{2'd3, 2'd2, 8'd9,   3'd3, 5'd4,  4'd4},  // R4 R5
    '{2'd3, 2'd3, 8'd0,   3'd7, 5'd0,  4'd4}   // R7
  };

  function automatic logic [7:0] pat(int s, int c);
    return 8'((s << 5) | c) ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_pos(input int p);
    do @(negedge clk); while (tcnt != p);
  endtask

  task automatic host_write(input int s, input int c, input logic [7:0] d);
    wr_valid = 1'b1; wr_stream = 2'(s); wr_chan = 5'(c); wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic host_read(input int s, input int c, output logic [7:0] d, input string req);
    rd_valid = 1'b1; rd_stream = 2'(s); rd_chan = 5'(c);
    @(negedge clk);
    rd_valid = 1'b0;
    chk(rsp_valid === 1'b1, "R11 rsp_valid", {7'd0, rsp_valid}, 8'd1);
    d = rsp_data;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R11 rsp single", {7'd0, rsp_valid}, 8'd0);
    if (req.len() == 0) d = d;
  endtask

  // R6: bit i of slot k sampled in the middle of its cell
  task automatic slot_bits(input int pin, input int k, input int d, output logic [7:0] got);
    for (int b = 0; b < 8; b++) begin
      wait_pos(k * 8 * d + b * d + d / 2);
      got[7 - b] = ser_out[pin];
    end
  endtask

  logic [7:0] got;
  logic [1:0] cur;
  bit         synced;

  initial begin
    // R12: no readiness during reset
    repeat (3) @(negedge clk);
    chk(wr_ready === 1'b0 && rd_ready === 1'b0, "R12 ready in reset",
        {6'd0, wr_ready, rd_ready}, 8'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(wr_ready === 1'b1 && rd_ready === 1'b1, "R12 ready after reset",
        {6'd0, wr_ready, rd_ready}, 8'd3);
    chk(ser_oe === 4'hF, "R8 reset arrangement 0 (R7 enables)", {4'd0, ser_oe}, 8'h0F);
    chk(rsp_valid === 1'b0, "R11 idle response", {7'd0, rsp_valid}, 8'd0);

    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 32; c++) host_write(s, c, pat(s, c));

    // table walk: R1-style mapping per arrangement, R5 interleave, R6 order, R7 idle
    synced = 1'b0;
    cur = 2'd0;
    for (int i = 0; i < 12; i++) begin
      if (!synced || cur != VEC[i].arr) begin
        arr_sel = VEC[i].arr;
        cur = VEC[i].arr;
        synced = 1'b1;
        wait_pos(100); wait_pos(0);
      end
      if (VEC[i].s == 3'd7) begin
        wait_pos(int'(VEC[i].k) * 8 * int'(VEC[i].d) + int'(VEC[i].d) / 2);
        chk(ser_out[VEC[i].pin] === 1'b1 && ser_oe[VEC[i].pin] === 1'b0, "R7 unused pin",
            {6'd0, ser_out[VEC[i].pin], ser_oe[VEC[i].pin]}, 8'd2);
      end else begin
        slot_bits(int'(VEC[i].pin), int'(VEC[i].k), int'(VEC[i].d), got);
        chk(got === pat(int'(VEC[i].s), int'(VEC[i].c)), $sformatf("R5/R6 vector %0d", i),
            got, pat(int'(VEC[i].s), int'(VEC[i].c)));
      end
    end

    // R10: write during the slot itself does not alter the byte already fetched
    wait_pos(320);
    host_write(0, 5, 8'h3C);
    slot_bits(0, 5, 8, got);
    chk(got === pat(0, 5), "R10 old byte in slot", got, pat(0, 5));
    slot_bits(0, 5, 8, got);
    chk(got === 8'h3C, "R10 new byte next frame", got, 8'h3C);

    // R9: loopback round trip in the mixed arrangement (R4)
    wait_pos(1000);
    host_read(0, 5, got, "R9");
    chk(got === 8'h3C, "R9 rx s0c5", got, 8'h3C);
    host_read(3, 4, got, "R9");
    chk(got === pat(3, 4), "R9 rx s3c4", got, pat(3, 4));
    host_read(1, 31, got, "R9");
    chk(got === pat(1, 31), "R9 rx s1c31", got, pat(1, 31));

    // R8: new arrangement waits for the frame boundary
    wait_pos(500);
    arr_sel = 2'd2;
    wait_pos(2047);
    chk(ser_oe === 4'b0111, "R8 before boundary", {4'd0, ser_oe}, 8'h07);
    wait_pos(0);
    chk(ser_oe === 4'b0001, "R8 at boundary", {4'd0, ser_oe}, 8'h01);

    // R9: loopback round trip with all streams on pin 0 (R3)
    wait_pos(100); wait_pos(0); wait_pos(50);
    host_read(2, 17, got, "R9");
    chk(got === pat(2, 17), "R9 rx s2c17", got, pat(2, 17));
    host_read(0, 5, got, "R9");
    chk(got === 8'h3C, "R9 rx s0c5 x8", got, 8'h3C);
    host_read(3, 31, got, "R9");
    chk(got === pat(3, 31), "R9 rx s3c31", got, pat(3, 31));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule